// File: doc/BRIEF.md
# Address Region Bounds Checker

This block checks the effective address of every load and store against the legal regions of an application address space. It holds three independently programmable regions: globals, heap and stack. It raises a fault symptom when an enabled check finds an access that lies in none of them, or that lies in the reserved upper part of the space. Software sets the globals region once when the program is loaded. It moves the heap bounds each time the allocator hands out memory, and moves the stack bounds on function entry and exit.

Each cycle the pipeline presents an address strobe with a 64-bit address. One cycle later the block returns a single-cycle violation pulse. The first violation is also held in a sticky flag, together with the address that caused it, until software clears the flag. Limits and control are written through a narrow register-write port that is indexed by a small selector.

Top module: `addr_bounds_guard`

## Requirements
- R1: After reset no violation pulse is given, the sticky flag is clear, the captured address is zero and every region is disabled.
- R2: An access whose address lies inside any one enabled region, and below 0x1_0000_0000, is legal and gives no pulse.
- R3: An access that lies outside all enabled regions, while at least one region is enabled, gives a violation pulse exactly one cycle after the strobe, lasting one cycle.
- R4: A region covers its lower bound and excludes its upper bound: address == lower is legal, and address == upper is not legal through that region.
- R5: A disabled region makes no address legal. When all three regions are disabled, no access is ever flagged.
- R6: Any access at or above 0x1_0000_0000 is a violation whenever at least one region is enabled, whatever the region bounds are.
- R7: A register write takes effect on the cycle after it is made. An access presented in the same cycle as a write is judged against the old values.
- R8: The sticky flag sets on a violation and captures its address. Later violations leave the captured address unchanged while the flag stays set.
- R9: Writing the control register with bit 8 set clears the sticky flag. A violation in the same cycle as that write is captured afresh.
- R10: Write selector map: 0/1 are the globals lower/upper bounds, 2/3 the heap bounds, 4/5 the stack bounds. Selector 6 is control: bits 0, 1 and 2 enable globals, heap and stack, and bit 8 is the clear. A write to selector 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Load/store address strobe |
| acc_addr | input | 64 | Effective address of the access |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register selector |
| cfg_wdata | input | 64 | Register write data |
| viol_pulse | output | 1 | One-cycle violation indication |
| viol_sticky | output | 1 | Held violation flag |
| viol_addr | output | 64 | Address of the first held violation |

## Verification
A bound register that holds a wrong value shows up one cycle after the first access that lands on the affected edge: a pulse appears where none belongs, or the expected pulse is missing. This is why accesses are placed exactly on each lower and upper bound. A wrong enable or sticky state shows on the next strobe as a wrong pulse, or as a captured address that differs from the first offending one. Write-versus-access ordering is tested by presenting both in the same cycle and then repeating the access alone.

// File: rtl/addr_bounds_guard.sv
module addr_bounds_guard #(
  parameter int AW = 64,
  parameter int NREG = 3,
  parameter int SELW = 3,
  parameter int CTRL_IDX = 6,
  parameter int CLR_BIT = 8,
  parameter logic [AW-1:0] APP_TOP = 64'h1_0000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          cfg_we,
  input  logic [SELW-1:0] cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          viol_pulse,
  output logic          viol_sticky,
  output logic [AW-1:0] viol_addr
);

  logic [NREG-1:0] en_q;
  logic [NREG-1:0] hit;
  logic            ctrl_wr, clr, rsvd, bad;

  assign ctrl_wr = cfg_we && (cfg_sel == SELW'(CTRL_IDX));
  assign clr     = ctrl_wr && cfg_wdata[CLR_BIT];

  for (genvar r = 0; r < NREG; r++) begin : g_rgn
    localparam logic [SELW-1:0] LO_SEL = SELW'(2 * r);
    localparam logic [SELW-1:0] HI_SEL = SELW'(2 * r + 1);
    logic [AW-1:0] lo_q, hi_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (cfg_we) begin
        if (cfg_sel == LO_SEL) lo_q <= cfg_wdata;
        if (cfg_sel == HI_SEL) hi_q <= cfg_wdata;
      end
    end

    assign hit[r] = en_q[r] && (acc_addr >= lo_q) && (acc_addr < hi_q);
  end

  assign rsvd = acc_addr >= APP_TOP;
  assign bad  = acc_valid && (|en_q) && (rsvd || !(|hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q        <= '0;
      viol_pulse  <= 1'b0;
      viol_sticky <= 1'b0;
      viol_addr   <= '0;
    end else begin
      if (ctrl_wr) en_q <= cfg_wdata[NREG-1:0];
      viol_pulse <= bad;
      if (bad && (!viol_sticky || clr)) begin
        viol_sticky <= 1'b1;
        viol_addr   <= acc_addr;
      end else if (clr) begin
        viol_sticky <= 1'b0;
      end
    end
  end

endmodule

module addr_bounds_guard_chk #(
  parameter int AW = 64,
  parameter int NREG = 3,
  parameter int SELW = 3,
  parameter int CTRL_IDX = 6,
  parameter int CLR_BIT = 8,
  parameter logic [AW-1:0] APP_TOP = 64'h1_0000_0000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_valid,
  input logic [AW-1:0]   acc_addr,
  input logic            cfg_we,
  input logic [SELW-1:0] cfg_sel,
  input logic [AW-1:0]   cfg_wdata,
  input logic            viol_pulse,
  input logic            viol_sticky,
  input logic [AW-1:0]   viol_addr,
  input logic [NREG-1:0] en_q
);

  logic clr_w;
  assign clr_w = cfg_we && (cfg_sel == SELW'(CTRL_IDX)) && cfg_wdata[CLR_BIT];

  // R3
  pulse_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> $past(acc_valid));

  // R6
  reserved_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_addr >= APP_TOP) && (|en_q)) |=> viol_pulse);

  // R5
  all_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (en_q == '0)) |=> !viol_pulse);

  // R8
  sticky_addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_sticky && !clr_w) |=> (viol_sticky && $stable(viol_addr)));

  // R8
  sticky_rise_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_sticky) |-> viol_pulse);

endmodule

bind addr_bounds_guard addr_bounds_guard_chk #(
  .AW(AW), .NREG(NREG), .SELW(SELW), .CTRL_IDX(CTRL_IDX), .CLR_BIT(CLR_BIT), .APP_TOP(APP_TOP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .viol_pulse(viol_pulse), .viol_sticky(viol_sticky), .viol_addr(viol_addr),
  .en_q(en_q)
);

// File: tb/test_addr_bounds_guard.sv
module test_addr_bounds_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [63:0] acc_addr = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [63:0] cfg_wdata = '0;
  logic        viol_pulse, viol_sticky;
  logic [63:0] viol_addr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  addr_bounds_guard i_addr_bounds_guard (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .viol_pulse(viol_pulse), .viol_sticky(viol_sticky), .viol_addr(viol_addr)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic acc(input logic [63:0] a, input bit exp_p, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
    chk(viol_pulse == exp_p, tag, 64'(viol_pulse), 64'(exp_p));
  endtask

  task automatic clear_sticky();
    wr(3'd6, 64'h107);
    chk(viol_sticky == 1'b0, "R9 clear", 64'(viol_sticky), 64'd0);
  endtask

  task automatic t_reset();
    chk(viol_pulse == 1'b0, "R1 pulse", 64'(viol_pulse), 64'd0);
    chk(viol_sticky == 1'b0, "R1 sticky", 64'(viol_sticky), 64'd0);
    chk(viol_addr == 64'd0, "R1 addr", viol_addr, 64'd0);
    acc(64'h2_0000_0000, 1'b0, "R1 R5 all disabled");
  endtask

  task automatic t_setup();
    wr(3'd0, 64'h1000);       wr(3'd1, 64'h2000);
    wr(3'd2, 64'h10000);      wr(3'd3, 64'h20000);
    wr(3'd4, 64'hF000_0000);  wr(3'd5, 64'hF800_0000);
    wr(3'd6, 64'h7);
  endtask

  task automatic t_inside();
    acc(64'h1000, 1'b0, "R4 lower inclusive");
    acc(64'h1FFF, 1'b0, "R2 globals top");
    acc(64'h18000, 1'b0, "R2 heap");
    acc(64'hF000_0000, 1'b0, "R2 stack");
    acc(64'h2000, 1'b1, "R4 upper exclusive");
    chk(viol_sticky && viol_addr == 64'h2000, "R8 capture", viol_addr, 64'h2000);
    @(negedge clk);
    chk(viol_pulse == 1'b0, "R3 one cycle", 64'(viol_pulse), 64'd0);
    acc(64'h3000, 1'b1, "R3 gap");
    chk(viol_addr == 64'h2000, "R8 first kept", viol_addr, 64'h2000);
    clear_sticky();
  endtask

  task automatic t_reserved();
    wr(3'd5, 64'hFFFF_FFFF_FFFF_FFFF);
    acc(64'h1_0000_0000, 1'b1, "R6 reserved");
    wr(3'd5, 64'hF800_0000);
    clear_sticky();
  endtask

  task automatic t_disable();
    wr(3'd6, 64'h5);
    acc(64'h18000, 1'b1, "R5 heap off");
    acc(64'h1800, 1'b0, "R5 globals still on");
    clear_sticky();
  endtask

  task automatic t_timing();
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd3; cfg_wdata = 64'h30000;
    acc_valid = 1'b1; acc_addr = 64'h28000;
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
    chk(viol_pulse == 1'b1, "R7 old limit", 64'(viol_pulse), 64'd1);
    acc(64'h28000, 1'b0, "R7 new limit");
    clear_sticky();
  endtask

  task automatic t_clr_same();
    acc(64'h5000, 1'b1, "R9 setup violation");
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd6; cfg_wdata = 64'h107;
    acc_valid = 1'b1; acc_addr = 64'h6000;
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
    chk(viol_sticky && viol_addr == 64'h6000, "R9 recapture", viol_addr, 64'h6000);
    clear_sticky();
  endtask

  task automatic t_ignored();
    wr(3'd7, 64'h0);
    acc(64'h1000, 1'b0, "R10 sel7 no effect legal");
    acc(64'h2000, 1'b1, "R10 sel7 no effect illegal");
    clear_sticky();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup();
    t_inside();
    t_reserved();
    t_disable();
    t_timing();
    t_clr_same();
    t_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule